// File: doc/BRIEF.md
# Guarded Countdown Timer

The block is a 32-bit down-counter on a simple register bus that runs either as an ordinary interval timer or as a guard timer. As an interval timer it counts down at a programmable rate, optionally restarts from its load value, and raises a level interrupt when it reaches zero. In guard mode, reaching zero instead produces a single-cycle reset request and records that event in a sticky flag that software can inspect later.

Software can enter guard mode with one control write. It cannot leave guard mode through the control register. The only way out is a fixed pair of 32-bit keys, written one after the other to the disable register. Any other bus write between the two keys cancels the attempt, so stray or runaway writes cannot turn the guard off.

Top module: `guard_timer`

## Requirements
- R1: After reset every readable register returns 0, and `irq` and `rst_req` are low.
- R2: A write to offset 0x20 sets both the load value and the running count, and both offsets 0x20 and 0x24 read back the written word. A write to offset 0x24 is ignored.
- R3: While control bit 0 (enable) is 1, the count drops by one every P+1 clock cycles, where P is control bits 15:8. While enable is 0, the count holds its value.
- R4: The tick that takes the count from 1 is an expiry. At an expiry the count becomes 0, or becomes the load value when control bit 1 (auto-restart) is 1. A count of 0 never decrements.
- R5: An expiry outside guard mode sets bit 0 of the status register at 0x2C. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. `irq` equals this flag ANDed with control bit 2.
- R6: Control bit 3 (guard mode) is set by writing 1 to it. Writing 0 to it through the control register leaves it set.
- R7: An expiry in guard mode drives `rst_req` high for exactly the next cycle and sets bit 0 of the register at 0x30. It does not set the interrupt flag.
- R8: Writing 1 to bit 0 of offset 0x30 clears the flag, and writing 0 leaves it unchanged.
- R9: Writing 0x12345678 and then 0x87654321 to offset 0x34 clears guard mode, provided no other write falls between the two. Idle cycles and reads between them are allowed.
- R10: Any write other than the second key after the first key, to any offset and with any data, cancels the sequence. The second key alone does nothing.
- R11: The control register reads as P in bits 15:8 and guard, interrupt enable, auto-restart and enable in bits 3..0, with all other bits 0. Offset 0x34 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |
| rst_req | output | 1 | One-cycle reset request from a guard expiry |

## Verification
The bench builds the block with its defaults: an 8-bit address and an 8-bit prescaler field. The count sequence is checked cycle by cycle for every prescale value from 0 to 3 combined with every load value from 1 to 4. Short loads make every expiry, with and without auto-restart, reachable within a few dozen cycles, so expected counts come straight from floor division of the elapsed cycles. The key sequence is checked with every kind of interruption: a write to another register, a wrong word to the disable register, the second key alone, and idle cycles between the keys.

// File: rtl/gtmr_pkg.sv
`timescale 1ns/1ps
package gtmr_pkg;

    localparam int unsigned DW = 32;

    // register byte offsets
    localparam int unsigned OFF_LOAD = 'h20;
    localparam int unsigned OFF_CNT  = 'h24;
    localparam int unsigned OFF_CTL  = 'h28;
    localparam int unsigned OFF_IST  = 'h2C;
    localparam int unsigned OFF_RST  = 'h30;
    localparam int unsigned OFF_DIS  = 'h34;

    // control field positions
    localparam int unsigned CTL_EN  = 0;
    localparam int unsigned CTL_RL  = 1;
    localparam int unsigned CTL_IE  = 2;
    localparam int unsigned CTL_WD  = 3;
    localparam int unsigned PSC_LSB = 8;

    localparam logic [DW-1:0] KEY_FIRST  = 32'h1234_5678;
    localparam logic [DW-1:0] KEY_SECOND = 32'h8765_4321;

    typedef struct packed {
        logic wd;
        logic ie;
        logic rl;
        logic en;
    } ctl_flags_t;

endpackage

// File: rtl/gtmr_prescale.sv
`timescale 1ns/1ps
module gtmr_prescale #(
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q >= div);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gtmr_unlock.sv
`timescale 1ns/1ps
module gtmr_unlock
    import gtmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          hit_dis,
    input  logic [DW-1:0] wdata,
    output logic          unlock
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        if (wr) begin
            // any write re-decides; only the first key arms
            armed_d = hit_dis && (wdata == KEY_FIRST);
        end
        unlock = wr && hit_dis && armed_q && (wdata == KEY_SECOND);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end
endmodule

// File: rtl/gtmr_counter.sv
`timescale 1ns/1ps
module gtmr_counter
    import gtmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          reload_en,
    input  logic          ld_wr,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] count,
    output logic [DW-1:0] load,
    output logic          expire
);
    typedef struct packed {
        logic [DW-1:0] load;
        logic [DW-1:0] count;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = tick && !ld_wr && (s_q.count == DW'(1));
        if (ld_wr) begin
            s_d.load  = ld_val;
            s_d.count = ld_val;
        end else if (tick && (s_q.count != '0)) begin
            if (expire) s_d.count = reload_en ? s_q.load : '0;
            else        s_d.count = s_q.count - DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.count;
    assign load  = s_q.load;
endmodule

// File: rtl/guard_timer.sv
`timescale 1ns/1ps
module guard_timer
    import gtmr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned PRESC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFF_LOAD);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);
    localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(OFF_IST);
    localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(OFF_RST);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFF_DIS);

    typedef struct packed {
        ctl_flags_t         flags;
        logic [PRESC_W-1:0] psc;
        logic               evt;
        logic               rsent;
        logic               rst_pulse;
    } top_state_t;

    top_state_t s_d, s_q;

    logic          tick, unlock, expire, ld_wr;
    logic [DW-1:0] count, load;
    logic          wd_mode, ie_on, evt_flag, rsent_flag, reload_en;

    assign ld_wr = bus_we && (bus_addr == A_LOAD);

    gtmr_prescale #(.PW(PRESC_W)) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (s_q.flags.en),
        .div  (s_q.psc),
        .tick (tick)
    );

    gtmr_unlock u_unl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_we),
        .hit_dis(bus_addr == A_DIS),
        .wdata  (bus_wdata),
        .unlock (unlock)
    );

    gtmr_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .reload_en(s_q.flags.rl),
        .ld_wr    (ld_wr),
        .ld_val   (bus_wdata),
        .count    (count),
        .load     (load),
        .expire   (expire)
    );

    always_comb begin
        s_d           = s_q;
        s_d.rst_pulse = 1'b0;
        if (bus_we && (bus_addr == A_CTL)) begin
            s_d.flags.en = bus_wdata[CTL_EN];
            s_d.flags.rl = bus_wdata[CTL_RL];
            s_d.flags.ie = bus_wdata[CTL_IE];
            s_d.flags.wd = s_q.flags.wd | bus_wdata[CTL_WD];
            s_d.psc      = bus_wdata[PSC_LSB +: PRESC_W];
        end
        if (unlock) s_d.flags.wd = 1'b0;
        if (bus_we && (bus_addr == A_IST) && bus_wdata[0]) s_d.evt   = 1'b0;
        if (bus_we && (bus_addr == A_RST) && bus_wdata[0]) s_d.rsent = 1'b0;
        if (expire) begin
            if (s_q.flags.wd) begin
                s_d.rsent     = 1'b1;
                s_d.rst_pulse = 1'b1;
            end else begin
                s_d.evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_LOAD: bus_rdata = load;
            A_CNT:  bus_rdata = count;
            A_CTL: begin
                bus_rdata[CTL_EN] = s_q.flags.en;
                bus_rdata[CTL_RL] = s_q.flags.rl;
                bus_rdata[CTL_IE] = s_q.flags.ie;
                bus_rdata[CTL_WD] = s_q.flags.wd;
                bus_rdata[PSC_LSB +: PRESC_W] = s_q.psc;
            end
            A_IST:  bus_rdata[0] = s_q.evt;
            A_RST:  bus_rdata[0] = s_q.rsent;
            default: bus_rdata = '0;
        endcase
    end

    assign irq        = s_q.evt & s_q.flags.ie;
    assign rst_req    = s_q.rst_pulse;
    assign wd_mode    = s_q.flags.wd;
    assign ie_on      = s_q.flags.ie;
    assign evt_flag   = s_q.evt;
    assign rsent_flag = s_q.rsent;
    assign reload_en  = s_q.flags.rl;
endmodule

// File: rtl/gtmr_checks.sv
`timescale 1ns/1ps
module gtmr_checks
    import gtmr_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          rst_req,
    input logic          wd_mode,
    input logic          ie_on,
    input logic          evt_flag,
    input logic          rsent_flag,
    input logic          unlock,
    input logic          ld_wr,
    input logic          expire,
    input logic          reload_en,
    input logic [DW-1:0] count
);
    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie_on);

    p_wd_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wd_mode) && !$past(unlock)) |-> wd_mode);

    p_rst_needs_wd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(wd_mode));

    p_rst_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> rsent_flag);

    p_no_evt_in_wd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flag) |-> !$past(wd_mode));

    p_count_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count > $past(count)) |-> ($past(ld_wr) || $past(expire && reload_en)));
endmodule

bind guard_timer gtmr_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .rst_req   (rst_req),
    .wd_mode   (wd_mode),
    .ie_on     (ie_on),
    .evt_flag  (evt_flag),
    .rsent_flag(rsent_flag),
    .unlock    (unlock),
    .ld_wr     (ld_wr),
    .expire    (expire),
    .reload_en (reload_en),
    .count     (count)
);

// File: tb/tb_guard_timer.sv
`timescale 1ns/1ps
module tb_guard_timer;
    localparam int ADDR_W = 8;
    localparam logic [7:0] A_LOAD = 8'h20, A_CNT = 8'h24, A_CTL = 8'h28,
                           A_IST = 8'h2C, A_RST = 8'h30, A_DIS = 8'h34;
    localparam logic [31:0] K1 = 32'h1234_5678, K2 = 32'h8765_4321;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq, rst_req;

    int errs = 0;
    int checks = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    guard_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; consumes exactly one rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_LOAD, rv); chk("R1 load", rv, 0);
        rd(A_CNT, rv);  chk("R1 count", rv, 0);
        rd(A_CTL, rv);  chk("R1 ctrl", rv, 0);
        rd(A_IST, rv);  chk("R1 status", rv, 0);
        rd(A_RST, rv);  chk("R1 rsent", rv, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 rst_req", {31'b0, rst_req}, 0);

        // R2 load writes both, count offset ignores writes
        wr(A_LOAD, 32'h0000_1234);
        rd(A_LOAD, rv); chk("R2 load readback", rv, 32'h1234);
        rd(A_CNT, rv);  chk("R2 count loaded", rv, 32'h1234);
        wr(A_CNT, 32'h5);
        rd(A_CNT, rv);  chk("R2 count write ignored", rv, 32'h1234);

        // R11 control layout and dead offsets
        wr(A_CTL, 32'hFFFF_FFF7);
        rd(A_CTL, rv);  chk("R11 ctrl layout", rv, 32'h0000_FF07);
        wr(A_CTL, 32'h0);
        rd(A_DIS, rv);  chk("R11 disable reads 0", rv, 0);
        rd(8'h10, rv);  chk("R11 unmapped reads 0", rv, 0);

        // R3/R4/R5 sweep prescale and load
        for (int p = 0; p < 4; p++) begin
            for (int n = 1; n < 5; n++) begin
                logic seen_rst;
                seen_rst = 1'b0;
                wr(A_CTL, 32'h0);
                wr(A_IST, 32'h1);
                wr(A_LOAD, n);
                wr(A_CTL, (p << 8) | 1);
                bus_addr = A_CNT;
                for (int k = 1; k <= n * (p + 1) + 3; k++) begin
                    int t;
                    int e;
                    @(negedge clk);
                    if (rst_req) seen_rst = 1'b1;
                    t = k / (p + 1);
                    e = (t >= n) ? 0 : n - t;
                    rd(A_CNT, rv);
                    chk("R3 R4 count sequence", rv, e);
                end
                chk("R7 no rst_req outside guard", {31'b0, seen_rst}, 0);
                rd(A_IST, rv); chk("R5 status set", rv, 1);
                chk("R5 irq masked", {31'b0, irq}, 0);
                wr(A_CTL, 32'h4);
                chk("R5 irq enabled", {31'b0, irq}, 1);
                wr(A_IST, 32'h0);
                rd(A_IST, rv); chk("R5 write 0 keeps", rv, 1);
                wr(A_IST, 32'h1);
                rd(A_IST, rv); chk("R5 w1c", rv, 0);
                chk("R5 irq low", {31'b0, irq}, 0);
            end
        end

        // R3 enable low holds count
        wr(A_CTL, 32'h0);
        wr(A_LOAD, 32'd10);
        wr(A_CTL, 32'h1);
        repeat (3) @(negedge clk);
        rd(A_CNT, rv); chk("R3 running", rv, 7);
        wr(A_CTL, 32'h0);
        repeat (5) @(negedge clk);
        rd(A_CNT, rv); chk("R3 hold when disabled", rv, 6);

        // R4 auto-restart, P=1, load 3
        wr(A_LOAD, 32'd3);
        wr(A_CTL, 32'h0103);
        for (int k = 1; k <= 14; k++) begin
            int t;
            @(negedge clk);
            t = k / 2;
            rd(A_CNT, rv);
            chk("R4 reload sequence", rv, 3 - (t % 3));
        end
        wr(A_CTL, 32'h0);
        wr(A_IST, 32'h1);

        // R6 guard bit sticky
        wr(A_CTL, 32'h8);
        rd(A_CTL, rv); chk("R6 set guard", rv, 32'h8);
        wr(A_CTL, 32'h0);
        rd(A_CTL, rv); chk("R6 write 0 keeps guard", rv, 32'h8);

        // R7 guard expiry
        wr(A_LOAD, 32'd2);
        wr(A_CTL, 32'h9);
        @(negedge clk);
        chk("R7 no early rst_req", {31'b0, rst_req}, 0);
        @(negedge clk);
        chk("R7 rst_req pulse", {31'b0, rst_req}, 1);
        rd(A_RST, rv); chk("R7 rsent set", rv, 1);
        rd(A_IST, rv); chk("R7 no status in guard", rv, 0);
        @(negedge clk);
        chk("R7 pulse one cycle", {31'b0, rst_req}, 0);

        // R8 reset-sent clearing
        wr(A_RST, 32'h0);
        rd(A_RST, rv); chk("R8 write 0 keeps", rv, 1);
        wr(A_RST, 32'h1);
        rd(A_RST, rv); chk("R8 w1c", rv, 0);

        // R10 broken sequences
        wr(A_DIS, K2);
        rd(A_CTL, rv); chk("R10 second key alone", rv, 32'h9);
        wr(A_DIS, K1); wr(A_IST, 32'h0); wr(A_DIS, K2);
        rd(A_CTL, rv); chk("R10 other register write", rv, 32'h9);
        wr(A_DIS, K1); wr(A_DIS, 32'hDEAD_BEEF); wr(A_DIS, K2);
        rd(A_CTL, rv); chk("R10 wrong word", rv, 32'h9);

        // R9 good sequence with idle and read between
        wr(A_DIS, K1);
        repeat (3) @(negedge clk);
        rd(A_LOAD, rv);
        wr(A_DIS, K2);
        rd(A_CTL, rv); chk("R9 unlock clears guard", rv, 32'h1);
        wr(A_CTL, 32'h8);
        wr(A_DIS, K1); wr(A_DIS, K2);
        rd(A_CTL, rv); chk("R9 back-to-back keys", rv, 32'h0);
        wr(A_CTL, 32'h0);
        rd(A_CTL, rv); chk("R6 stays clear", rv, 32'h0);

        report();
    end
endmodule